// File: doc/BRIEF.md
# SD Card SPI-Mode Block Write Sequencer

This block runs the data phase of a block write to an SD card operating in SPI mode, once the write command has already been issued and accepted elsewhere. On a start strobe it takes a block count, a block size and a single/multi flag. It then pulls payload bytes from a valid/ready stream and pushes every byte it sends over a one-byte-at-a-time exchange link. That link is served by an SPI shifter outside this block, which returns the byte clocked in from the card for each byte sent.

Each block goes out as a 0xFF filler, a start token, the payload and a CRC16 computed while the payload passes through, so no block buffer is needed. The sequencer then hunts for the card's data-response token. It ends the transfer on a rejection, or polls through the card's busy period with a bounded poll count. In multi-block mode a clean run is closed with a stop token and a last busy wait. The result is a two-bit status code, qualified by a one-cycle done pulse.

Top module: `sd_blk_writer`

## Requirements
- R1: For each block the sequencer sends 0xFF, then the start token (0xFE when `multi` is 0, 0xFC when `multi` is 1), then exactly `blk_size` payload bytes in stream order. `blk_size` must be at least 1.
- R2: After the payload it sends the CRC16 of that block's payload bytes, high byte first. The CRC uses polynomial 0x1021 with a zero initial value and processes each byte MSB first.
- R3: After the CRC it sends 0xFF polls, at most RESP_TRIES of them, and takes the first returned byte with bit 4 clear as the response token. If none has bit 4 clear, the last returned byte is decoded.
- R4: The response's low five bits decide the outcome. 0x05 accepts the block. 0x0D ends the transfer with status 2 (write rejected). Any other value ends it with status 1 (CRC rejected).
- R5: After an accept it sends 0xFF polls until a poll other than the first returns 0xFF. The first poll's value is ignored, even when it is 0xFF.
- R6: If POLL_LIMIT busy polls go by without success, the transfer ends with status 3 (busy timeout). A success on poll number POLL_LIMIT still counts as a success.
- R7: In multi mode, after every block has been accepted and has left busy, it sends 0xFF, then the stop token 0xFD, then runs the same busy wait. Status is 0 on success.
- R8: No stop token is sent after a transfer that ended on a rejection or a block timeout.
- R9: Status codes are 0 ok, 1 CRC rejected, 2 write rejected, 3 busy timeout. `done` is high for exactly one cycle per transfer. `status` is valid with `done` and holds until the next start.
- R10: With `blk_count` of 0, a single-mode start finishes with status 0 and sends no bytes. A multi-mode start sends only the stop sequence of R7.
- R11: `bx_req` stays high with a stable `bx_tx` until `bx_ack` arrives. A payload byte is taken on `in_valid && in_ready`. `in_ready` is high only in the payload phase while no byte is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Begin a transfer (sampled when idle) |
| blk_count | input | CNT_W | Number of blocks |
| blk_size | input | SIZE_W | Bytes per block, at least 1 |
| multi | input | 1 | 1 selects multi-block tokens and the stop sequence |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte taken this cycle when valid |
| bx_req | output | 1 | Byte exchange request to the SPI shifter |
| bx_tx | output | 8 | Byte to send |
| bx_ack | input | 1 | One-cycle exchange complete |
| bx_rx | input | 8 | Byte received, valid with `bx_ack` |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | Result code (R9) |

## Verification
The bench aims at the busy wait's edges. A first poll that returns 0xFF must be skipped, or a design would accept a block while the card is still busy. A success on exactly the last allowed poll must not be reported as a timeout, and one poll more must be. It feeds a response search that never finds a token, which a careless design would leave hanging or report as accepted. It also sends rejections in multi mode, where a design that ignored the abort would still emit 0xFD. Zero-block starts, stalled payload streams and a card model that checks the CRC bytes and payload order byte by byte expose wrong token choice, CRC order or a dropped or repeated payload byte.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_CRCREJ = 2'd1,
    ST_WRREJ  = 2'd2,
    ST_TMO    = 2'd3
  } wr_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_TOK, S_PAY, S_CHI, S_CLO,
    S_RSP, S_BSY, S_SPRE, S_STOK, S_FIN
  } wr_state_e;

  localparam logic [7:0] BYTE_FILL   = 8'hFF;
  localparam logic [7:0] TOK_SINGLE  = 8'hFE;
  localparam logic [7:0] TOK_MULTI   = 8'hFC;
  localparam logic [7:0] TOK_STOP    = 8'hFD;
  localparam logic [4:0] RESP_ACCEPT = 5'h05;
  localparam logic [4:0] RESP_WRERR  = 5'h0D;

  // one byte through CRC16, polynomial 0x1021, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import sdw_pkg::*;

  logic [15:0] crc_q, crc_n;
  logic        crc_ce;

  assign crc_ce = clr | en;

  always_comb begin
    crc_n = crc_q;
    if (clr)     crc_n = 16'h0000;
    else if (en) crc_n = crc16_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= 16'h0000;
    else if (crc_ce) crc_q <= crc_n;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sdw_step_ctr.sv
module sdw_step_ctr #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic first,
  output logic last
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_ce;

  assign cnt_ce = clr | inc;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)      cnt_n = '0;
    else if (inc) cnt_n = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_n;
  end

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == LAST_V);
endmodule

// File: rtl/sd_blk_writer.sv
module sd_blk_writer #(
  parameter int CNT_W      = 16,
  parameter int SIZE_W     = 12,
  parameter int RESP_TRIES = 8,
  parameter int POLL_LIMIT = 3000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic [SIZE_W-1:0] blk_size,
  input  logic              multi,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              bx_req,
  output logic [7:0]        bx_tx,
  input  logic              bx_ack,
  input  logic [7:0]        bx_rx,
  output logic              done,
  output logic [1:0]        status
);
  import sdw_pkg::*;

  wr_state_e         state_q, state_n;
  logic              req_q, req_n;
  logic [7:0]        tx_q, tx_n;
  logic [CNT_W-1:0]  blk_left_q, blk_left_n;
  logic [SIZE_W-1:0] size_q, size_n, byte_left_q, byte_left_n;
  logic              multi_q, multi_n, stop_q, stop_n, done_q, done_n;
  wr_status_e        status_q, status_n;

  logic        crc_clr, crc_en;
  logic [15:0] crc_val;
  logic        rsp_clr, rsp_inc, rsp_first, rsp_last;
  logic        pol_clr, pol_inc, pol_first, pol_last;
  logic        issue, ack_hit, take;
  logic [7:0]  send_byte;
  logic [4:0]  rsp_code;

  sdw_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(in_data), .crc(crc_val)
  );

  sdw_step_ctr #(.LIMIT(RESP_TRIES)) u_rsp_ctr (
    .clk(clk), .rst_n(rst_n), .clr(rsp_clr), .inc(rsp_inc),
    .first(rsp_first), .last(rsp_last)
  );

  sdw_step_ctr #(.LIMIT(POLL_LIMIT)) u_poll_ctr (
    .clk(clk), .rst_n(rst_n), .clr(pol_clr), .inc(pol_inc),
    .first(pol_first), .last(pol_last)
  );

  assign in_ready = (state_q == S_PAY) && !req_q;
  assign take     = in_ready && in_valid;
  assign ack_hit  = req_q && bx_ack;
  assign rsp_code = bx_rx[4:0];

  always_comb begin
    state_n     = state_q;
    req_n       = req_q;
    tx_n        = tx_q;
    blk_left_n  = blk_left_q;
    size_n      = size_q;
    byte_left_n = byte_left_q;
    multi_n     = multi_q;
    stop_n      = stop_q;
    status_n    = status_q;
    done_n      = 1'b0;
    crc_clr     = 1'b0;
    crc_en      = 1'b0;
    rsp_clr     = 1'b0;
    rsp_inc     = 1'b0;
    pol_clr     = 1'b0;
    pol_inc     = 1'b0;
    issue       = 1'b0;
    send_byte   = BYTE_FILL;

    case (state_q)
      S_IDLE: begin
        if (start) begin
          multi_n    = multi;
          size_n     = blk_size;
          blk_left_n = blk_count;
          status_n   = ST_OK;
          stop_n     = 1'b0;
          if (blk_count != '0) state_n = S_PRE;
          else if (multi)      state_n = S_SPRE;
          else                 state_n = S_FIN;
        end
      end
      S_PRE: begin
        issue = 1'b1;
        if (ack_hit) begin
          crc_clr = 1'b1;
          state_n = S_TOK;
        end
      end
      S_TOK: begin
        issue     = 1'b1;
        send_byte = multi_q ? TOK_MULTI : TOK_SINGLE;
        if (ack_hit) begin
          byte_left_n = size_q;
          state_n     = S_PAY;
        end
      end
      S_PAY: begin
        if (take) begin
          req_n  = 1'b1;
          tx_n   = in_data;
          crc_en = 1'b1;
        end
        if (ack_hit) begin
          byte_left_n = byte_left_q - SIZE_W'(1);
          if (byte_left_q == SIZE_W'(1)) state_n = S_CHI;
        end
      end
      S_CHI: begin
        issue     = 1'b1;
        send_byte = crc_val[15:8];
        if (ack_hit) state_n = S_CLO;
      end
      S_CLO: begin
        issue     = 1'b1;
        send_byte = crc_val[7:0];
        if (ack_hit) begin
          rsp_clr = 1'b1;
          state_n = S_RSP;
        end
      end
      S_RSP: begin
        issue = 1'b1;
        if (ack_hit) begin
          rsp_inc = 1'b1;
          if (!bx_rx[4] || rsp_last) begin
            if (rsp_code == RESP_ACCEPT) begin
              pol_clr = 1'b1;
              state_n = S_BSY;
            end else begin
              status_n = (rsp_code == RESP_WRERR) ? ST_WRREJ : ST_CRCREJ;
              state_n  = S_FIN;
            end
          end
        end
      end
      S_BSY: begin
        issue = 1'b1;
        if (ack_hit) begin
          pol_inc = 1'b1;
          if (!pol_first && bx_rx == BYTE_FILL) begin
            if (stop_q) begin
              state_n = S_FIN;
            end else begin
              blk_left_n = blk_left_q - CNT_W'(1);
              if (blk_left_q != CNT_W'(1)) state_n = S_PRE;
              else if (multi_q)            state_n = S_SPRE;
              else                         state_n = S_FIN;
            end
          end else if (pol_last) begin
            status_n = ST_TMO;
            state_n  = S_FIN;
          end
        end
      end
      S_SPRE: begin
        issue = 1'b1;
        if (ack_hit) state_n = S_STOK;
      end
      S_STOK: begin
        issue     = 1'b1;
        send_byte = TOK_STOP;
        if (ack_hit) begin
          stop_n  = 1'b1;
          pol_clr = 1'b1;
          state_n = S_BSY;
        end
      end
      S_FIN: begin
        done_n  = 1'b1;
        stop_n  = 1'b0;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase

    if (ack_hit) req_n = 1'b0;
    else if (issue && !req_q) begin
      req_n = 1'b1;
      tx_n  = send_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      req_q       <= 1'b0;
      tx_q        <= 8'h00;
      blk_left_q  <= '0;
      size_q      <= '0;
      byte_left_q <= '0;
      multi_q     <= 1'b0;
      stop_q      <= 1'b0;
      status_q    <= ST_OK;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_n;
      req_q       <= req_n;
      tx_q        <= tx_n;
      blk_left_q  <= blk_left_n;
      size_q      <= size_n;
      byte_left_q <= byte_left_n;
      multi_q     <= multi_n;
      stop_q      <= stop_n;
      status_q    <= status_n;
      done_q      <= done_n;
    end
  end

  assign bx_req = req_q;
  assign bx_tx  = tx_q;
  assign done   = done_q;
  assign status = status_q;

  // R11: an outstanding byte is held unchanged until acknowledged
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !bx_ack) |=> (req_q && $stable(tx_q)));

  // R11: an accepted payload byte is the next byte put on the link
  assert_payload_forward_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (bx_req && bx_tx == $past(in_data)));

  // R8: the stop token is only reached by a clean multi-block run
  assert_stop_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STOK) |-> (multi_q && status_q == ST_OK));

  // R9: done lasts one cycle and no byte is outstanding with it
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !req_q);
endmodule

// File: tb/tb_sd_blk_writer.sv
`timescale 1ns/1ps
module tb_sd_blk_writer;
  localparam int CNT_W = 16, SIZE_W = 12, TRIES = 8, LIMIT = 16;

  typedef struct packed {
    logic [15:0] cnt;
    logic [11:0] size;
    logic        mlt;
    logic [3:0]  rdel;
    logic [7:0]  rcode;
    logic [7:0]  busy;
    logic [7:0]  first;
    logic        gap;
    logic [1:0]  est;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'd1, 12'd4, 1'b0, 4'd0, 8'hE5, 8'd3,  8'h00, 1'b0, 2'd0},
    '{16'd3, 12'd5, 1'b1, 4'd2, 8'h05, 8'd0,  8'hFF, 1'b1, 2'd0},
    '{16'd2, 12'd3, 1'b1, 4'd1, 8'h0B, 8'd2,  8'h00, 1'b0, 2'd1},
    '{16'd1, 12'd2, 1'b0, 4'd0, 8'h0D, 8'd2,  8'h00, 1'b0, 2'd2},
    '{16'd2, 12'd2, 1'b1, 4'd0, 8'h05, 8'd20, 8'h00, 1'b0, 2'd3},
    '{16'd1, 12'd3, 1'b0, 4'd8, 8'h05, 8'd1,  8'h00, 1'b0, 2'd1},
    '{16'd1, 12'd3, 1'b0, 4'd7, 8'h05, 8'd14, 8'hFF, 1'b1, 2'd0},
    '{16'd1, 12'd3, 1'b0, 4'd0, 8'h05, 8'd15, 8'h00, 1'b0, 2'd3},
    '{16'd0, 12'd4, 1'b1, 4'd0, 8'h05, 8'd3,  8'h00, 1'b0, 2'd0},
    '{16'd0, 12'd4, 1'b0, 4'd0, 8'h05, 8'd3,  8'h00, 1'b0, 2'd0},
    '{16'd0, 12'd4, 1'b1, 4'd0, 8'h05, 8'd20, 8'h00, 1'b0, 2'd3}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R1 R5 single ok";
      1: return "R5 R7 multi first-poll-FF ok";
      2: return "R4 R8 crc reject multi";
      3: return "R4 write reject";
      4: return "R6 R8 block timeout multi";
      5: return "R3 no response token";
      6: return "R3 R6 success on last poll";
      7: return "R6 one poll past limit";
      8: return "R10 R7 zero blocks multi";
      9: return "R10 zero blocks single";
      default: return "R6 R10 stop busy timeout";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [CNT_W-1:0] blk_count;
  logic [SIZE_W-1:0] blk_size;
  logic multi, in_valid, in_ready, bx_req, bx_ack, done;
  logic [7:0] in_data, bx_tx, bx_rx;
  logic [1:0] status;

  always #5 clk = ~clk;

  sd_blk_writer #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .RESP_TRIES(TRIES), .POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count), .blk_size(blk_size),
    .multi(multi), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .bx_req(bx_req), .bx_tx(bx_tx), .bx_ack(bx_ack), .bx_rx(bx_rx),
    .done(done), .status(status)
  );

  int checks = 0, failures = 0, cyc = 0;
  int txn = 0, fd_cnt = 0, tok_bad = 0, pay_bad = 0, crc_bad = 0, hold_bad = 0;
  int pay_idx = 0;
  logic [7:0] seed = 8'h00;
  logic gap_mode = 1'b0;

  // card model configuration and state
  localparam int C_IDLE = 0, C_DATA = 1, C_RESP = 2, C_BUSY = 3;
  int cst = C_IDLE, cj = 0, ck = 0;
  int c_size = 1, c_rdel = 0, c_busy = 0;
  logic [7:0] c_rcode = 8'h05, c_first = 8'h00, c_tok = 8'hFE, c_hi = 8'h00;
  logic [15:0] c_crc = 16'h0;

  assign in_data = seed + pay_idx[7:0];

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[15] != d[b]) r = (r << 1) ^ 16'h1021;
      else               r = r << 1;
    end
    return r;
  endfunction

  task automatic card_step(input logic [7:0] b, output logic [7:0] r);
    r = 8'hFF;
    case (cst)
      C_IDLE: begin
        if (b == 8'hFE || b == 8'hFC) begin
          if (b != c_tok) tok_bad++;
          cst = C_DATA; cj = 0; c_crc = 16'h0;
        end else if (b == 8'hFD) begin
          fd_cnt++;
          cst = C_BUSY; ck = 0;
        end else if (b != 8'hFF) tok_bad++;
      end
      C_DATA: begin
        if (cj < c_size) begin
          if (b != seed + pay_idx[7:0]) pay_bad++;
          pay_idx++;
          c_crc = ref_crc(c_crc, b);
        end else if (cj == c_size) c_hi = b;
        else begin
          if ({c_hi, b} != c_crc) crc_bad++;
          cst = C_RESP; ck = 0;
        end
        cj++;
      end
      C_RESP: begin
        if (ck < c_rdel) ck++;
        else begin
          r = c_rcode;
          cst = ((c_rcode & 8'h1F) == 8'h05) ? C_BUSY : C_IDLE;
          ck = 0;
        end
      end
      default: begin
        if (ck == 0)          r = c_first;
        else if (ck <= c_busy) r = 8'h00;
        else begin
          r = 8'hFF;
          cst = C_IDLE;
        end
        ck++;
      end
    endcase
  endtask

  // byte exchange responder with varying latency
  always begin
    @(negedge clk);
    if (bx_req) begin
      logic [7:0] r;
      for (int w = 0; w < (txn % 3); w++) @(negedge clk);
      card_step(bx_tx, r);
      bx_rx  = r;
      bx_ack = 1'b1;
      txn++;
      @(negedge clk);
      bx_ack = 1'b0;
    end
  end

  // payload stream, with optional gaps
  always @(negedge clk) begin
    cyc++;
    in_valid <= gap_mode ? cyc[1] : 1'b1;
  end

  // R11 hold monitor, sampled just after each edge
  logic p_req = 1'b0;
  logic [7:0] p_tx = 8'h00;
  always @(posedge clk) begin
    #1;
    if (rst_n && p_req && !bx_ack && (!bx_req || bx_tx != p_tx)) hold_bad++;
    p_req = bx_req;
    p_tx  = bx_tx;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic exp_calc(input vec_t v, output int n, output bit fd);
    int bp;
    int rp;
    logic [4:0] code;
    n = 0; fd = 1'b0;
    for (int b = 0; b < int'(v.cnt); b++) begin
      n += 4 + int'(v.size);
      rp = (v.rdel >= TRIES) ? TRIES : int'(v.rdel) + 1;
      n += rp;
      code = (v.rdel >= TRIES) ? 5'h1F : v.rcode[4:0];
      if (code != 5'h05) return;
      bp = int'(v.busy) + 2;
      if (bp > LIMIT) begin n += LIMIT; return; end
      n += bp;
    end
    if (v.mlt) begin
      fd = 1'b1;
      bp = int'(v.busy) + 2;
      n += 2 + ((bp > LIMIT) ? LIMIT : bp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int n, t;
    bit fd;
    v = VECS[i];
    exp_calc(v, n, fd);
    cst = C_IDLE; c_size = int'(v.size); c_rdel = int'(v.rdel); c_busy = int'(v.busy);
    c_rcode = v.rcode; c_first = v.first; c_tok = v.mlt ? 8'hFC : 8'hFE;
    txn = 0; fd_cnt = 0; tok_bad = 0; pay_bad = 0; crc_bad = 0;
    gap_mode = v.gap; seed = 8'(i * 37 + 5); pay_idx = 0;
    @(negedge clk);
    blk_count = v.cnt; blk_size = v.size; multi = v.mlt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check(done === 1'b1, {vtag(i), " R9 done seen"}, int'(done), 1);
    check(status === v.est, {vtag(i), " status"}, int'(status), int'(v.est));
    check(txn == n, {vtag(i), " byte count"}, txn, n);
    check(tok_bad == 0 && pay_bad == 0 && pay_idx == int'(v.size) * ((v.est == 0) ? int'(v.cnt) : pay_idx / ((v.size == 0) ? 1 : int'(v.size))),
          {vtag(i), " R1 token/payload"}, tok_bad + pay_bad, 0);
    check(crc_bad == 0, {vtag(i), " R2 crc bytes"}, crc_bad, 0);
    check(fd_cnt == int'(fd), {vtag(i), " R7 R8 stop token count"}, fd_cnt, int'(fd));
    @(negedge clk);
    check(done === 1'b0, {vtag(i), " R9 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; blk_count = '0; blk_size = '0; multi = 1'b0;
    bx_ack = 1'b0; bx_rx = 8'hFF; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && status === 2'd0, "R9 reset outputs", int'(status), 0);
    check(bx_req === 1'b0 && in_ready === 1'b0, "R11 reset link idle", int'(bx_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R9: status from the last error run holds while idle
    run_vec(3);
    repeat (6) @(negedge clk);
    check(status === 2'd2 && done === 1'b0, "R9 status held while idle", int'(status), 2);
    check(bx_req === 1'b0, "R9 no bytes while idle", int'(bx_req), 0);

    // R1 R2 back-to-back: long block with gaps right after a rejection
    run_vec(1);

    check(hold_bad == 0, "R11 request held until ack", hold_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule